// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a byte-wide host write bus and a small block-erasable flash array, modelled at the logic level. It decodes bus writes as commands. It runs byte programming and two-cycle block erases as timed internal operations. It keeps a status register that holds a ready bit, an erase-suspended bit and sticky failure flags, and it drives a ready pin. Reads return either array data or the status byte, depending on the current read mode.

An erase needs a setup write followed by a confirm write, both carrying an address inside the target block. Before starting any operation the controller checks a per-block lock input and a program-voltage-valid input. A running erase can be suspended after a fixed latency. While it is suspended, the host can read other blocks and program them, and then resume the erase from where it stopped.

The array has `NUM_BLOCKS` blocks of `BLOCK_BYTES` bytes each. `BLOCK_BYTES` is a power of two. An address is the block index in the upper bits over the byte offset in the lower bits. An erase takes `ERASE_CYCLES` cycles, a program takes `PROG_CYCLES` cycles and a suspend takes effect after `SUSPEND_LAT` cycles.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in read-array mode, `sts_pin` is 1 and every byte of the array reads 0xFF.
- R2: A write of 0x40 followed by a data write programs the addressed byte to (old value AND data). Status reads 0x00 (bit 7 = 0, `sts_pin` = 0) for `PROG_CYCLES` cycles after the data write, then 0x80.
- R3: A write of 0x20 followed by 0xD0 erases the block that holds the confirm address. For `ERASE_CYCLES` cycles after the confirm write, bit 7 reads 0 and `sts_pin` is 0. After that every byte of that block reads 0xFF and other blocks are unchanged.
- R4: If the write after 0x20 is not 0xD0, status bits 5 and 4 are set and no erase runs.
- R5: With `vpp_ok` low, an erase attempt sets bits 5 and 3 and a program attempt sets bits 4 and 3. The array is left unchanged in both cases.
- R6: With the target block's `lock_in` bit set, an erase attempt sets bits 5 and 1 and a program attempt sets bits 4 and 1. The array is left unchanged in both cases.
- R7: Bits 5, 4, 3 and 1 stay set until a write of 0x50. A 0x50 clears them only while no operation is running (idle or erase suspended), whatever the level of `vpp_ok`. A 0x50 written during a running operation is ignored.
- R8: After 0x20, 0x40, 0xD0 or an accepted 0xB0, reads return the status byte until 0xFF is written. After 0xFF, reads return array data. During an erase suspend this includes blocks other than the suspended one.
- R9: A 0xB0 written during an erase makes status read 0xC0 and `sts_pin` go to 1 exactly `SUSPEND_LAT` cycles later, with the block not yet erased. A 0xB0 written while idle has no effect.
- R10: While a program runs during a suspended erase, bit 7 is 0, `sts_pin` is 0 and bit 6 stays 1. The status returns to 0xC0 when the program ends. During the suspend, a program aimed at the suspended block sets bit 4, and any erase attempt sets bit 5.
- R11: A 0xD0 written during a suspend clears bit 6 and bit 7 at once. The erase then finishes after exactly the cycles it still had left. Cycles spent inside the suspend latency count as erase cycles.
- R12: If the erase count runs out while a suspend request is still pending, the erase completes and the controller goes idle (status 0x80) without ever entering the suspended state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address (block index over byte offset) |
| wr_data | input | 8 | Write data: command code or program byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Array byte or status byte, depending on read mode |
| vpp_ok | input | 1 | Program voltage valid |
| lock_in | input | NUM_BLOCKS | Per-block lock bits |
| sts_pin | output | 1 | Ready pin, mirrors status bit 7 |

## Verification
Two events can fall in the same cycle: the erase counter running out, and a pending suspend request whose latency has not yet expired. The bench provokes this by writing 0xB0 on the second-to-last erase cycle, so the erase completes while the suspend is still pending. Completion must win: status goes straight to 0x80, the block reads 0xFF and bit 6 never rises. A second case, with the suspend written early, checks that the latency and the leftover count add up exactly after resume.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_CLEAR       = 8'h50;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;

  // sticky error vector layout {erase, prog, vpp, lock}
  localparam int ERR_ERASE = 3;
  localparam int ERR_PROG  = 2;
  localparam int ERR_VPP   = 1;
  localparam int ERR_LOCK  = 0;

  typedef enum logic [2:0] {
    WS_IDLE, WS_ERASE, WS_SUSP_REQ, WS_SUSPENDED, WS_PROG
  } wsm_state_t;

  typedef enum logic [1:0] {PEND_NONE, PEND_ERASE, PEND_PROG} pend_t;

  function automatic logic [7:0] pack_status(logic ready, logic susp, logic [3:0] err);
    return {ready, susp, err[ERR_ERASE], err[ERR_PROG], err[ERR_VPP], 1'b0, err[ERR_LOCK], 1'b0};
  endfunction

  function automatic logic [7:0] program_byte(logic [7:0] old_v, logic [7:0] new_v);
    return old_v & new_v;
  endfunction

endpackage

// File: rtl/flash_cells.sv
module flash_cells
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_BYTES = 8,
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int OFF_W  = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1,
  localparam int ADDR_W = BLK_W + OFF_W,
  localparam int TOTAL  = NUM_BLOCKS * BLOCK_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_en,
  input  logic [BLK_W-1:0]  erase_blk,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_q
);

  logic [7:0] mem [TOTAL];
  logic [ADDR_W-1:0] first_addr;

  assign first_addr = {erase_blk, {OFF_W{1'b0}}};
  assign rd_q = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= 8'hFF;
    end else begin
      if (erase_en) begin
        for (int i = 0; i < TOTAL; i++)
          if ((i / BLOCK_BYTES) == int'(erase_blk)) mem[i] <= 8'hFF;
      end
      if (prog_en) mem[prog_addr] <= program_byte(mem[prog_addr], prog_data);
    end
  end

  // R3: after an erase pulse the first byte of that block reads erased
  assert_erase_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> mem[$past(first_addr)] == 8'hFF);

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_cmd_pkg::*;
#(
  parameter int ERASE_CYCLES = 40,
  parameter int SUSPEND_LAT  = 3,
  parameter int PROG_CYCLES  = 4,
  parameter int BLK_W        = 2,
  localparam int ECNT_W = $clog2(ERASE_CYCLES + 1),
  localparam int LCNT_W = $clog2(SUSPEND_LAT + 1),
  localparam int PCNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_erase,
  input  logic             start_prog,
  input  logic             req_susp,
  input  logic             req_resume,
  input  logic [BLK_W-1:0] erase_blk_i,
  output wsm_state_t       state_o,
  output logic             ready_o,
  output logic             susp_o,
  output logic [BLK_W-1:0] erase_blk_o,
  output logic             erase_done_o,
  output logic             prog_done_o
);

  localparam logic [ECNT_W-1:0] E_LAST = ECNT_W'(ERASE_CYCLES - 1);
  localparam logic [LCNT_W-1:0] L_LAST = LCNT_W'(SUSPEND_LAT - 1);
  localparam logic [PCNT_W-1:0] P_LAST = PCNT_W'(PROG_CYCLES - 1);

  wsm_state_t state;
  logic [ECNT_W-1:0] ecnt;
  logic [LCNT_W-1:0] lcnt;
  logic [PCNT_W-1:0] pcnt;
  logic ret_susp;
  logic susp_enter;

  assign erase_done_o = (state == WS_ERASE || state == WS_SUSP_REQ) && ecnt == E_LAST;
  assign susp_enter   = state == WS_SUSP_REQ && !erase_done_o && lcnt == L_LAST;
  assign prog_done_o  = state == WS_PROG && pcnt == P_LAST;
  assign ready_o      = state == WS_IDLE || state == WS_SUSPENDED;
  assign susp_o       = state == WS_SUSPENDED || (state == WS_PROG && ret_susp);
  assign state_o      = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= WS_IDLE;
      ecnt <= '0;
      lcnt <= '0;
      pcnt <= '0;
      ret_susp <= 1'b0;
      erase_blk_o <= '0;
    end else begin
      case (state)
        WS_IDLE: begin
          if (start_erase) begin
            state <= WS_ERASE;
            ecnt <= '0;
            erase_blk_o <= erase_blk_i;
          end else if (start_prog) begin
            state <= WS_PROG;
            pcnt <= '0;
            ret_susp <= 1'b0;
          end
        end
        WS_ERASE: begin
          if (erase_done_o) state <= WS_IDLE;
          else begin
            ecnt <= ecnt + 1'b1;
            if (req_susp) begin
              state <= WS_SUSP_REQ;
              lcnt <= '0;
            end
          end
        end
        WS_SUSP_REQ: begin
          if (erase_done_o) state <= WS_IDLE;
          else begin
            ecnt <= ecnt + 1'b1;
            if (susp_enter) state <= WS_SUSPENDED;
            else lcnt <= lcnt + 1'b1;
          end
        end
        WS_SUSPENDED: begin
          if (req_resume) state <= WS_ERASE;
          else if (start_prog) begin
            state <= WS_PROG;
            pcnt <= '0;
            ret_susp <= 1'b1;
          end
        end
        WS_PROG: begin
          if (prog_done_o) state <= ret_susp ? WS_SUSPENDED : WS_IDLE;
          else pcnt <= pcnt + 1'b1;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  // R11: resume keeps the erase count where it stopped
  assert_resume_continues_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_SUSPENDED && req_resume) |=> (state == WS_ERASE && ecnt == $past(ecnt)));

  // R12: a finished erase never lands in the suspended state
  assert_complete_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done_o |=> (state == WS_IDLE && !susp_o));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLOCKS   = 4,
  parameter int BLOCK_BYTES  = 8,
  parameter int ERASE_CYCLES = 40,
  parameter int SUSPEND_LAT  = 3,
  parameter int PROG_CYCLES  = 4,
  localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int OFF_W  = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1,
  localparam int ADDR_W = BLK_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [7:0]            rd_data,
  input  logic                  vpp_ok,
  input  logic [NUM_BLOCKS-1:0] lock_in,
  output logic                  sts_pin
);

  wsm_state_t wsm_state;
  logic wsm_ready, wsm_susp, erase_done, prog_done;
  logic [BLK_W-1:0] act_blk, wr_blk;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0] op_data, cell_q, status;
  logic [3:0] err_q, set_err;
  pend_t pend_q, pend_n;
  logic read_status, mode_n;
  logic accept, start_erase, start_prog, clr_fire, resume_fire, susp_fire;
  logic blk_locked;

  assign wr_blk     = wr_addr[ADDR_W-1 -: BLK_W];
  assign blk_locked = lock_in[wr_blk];
  assign accept     = wr_en && wsm_ready;

  always_comb begin
    set_err = '0;
    start_erase = 1'b0;
    start_prog = 1'b0;
    clr_fire = 1'b0;
    resume_fire = 1'b0;
    susp_fire = 1'b0;
    pend_n = pend_q;
    mode_n = read_status;
    if (wr_en && wsm_state == WS_ERASE && wr_data == CMD_SUSPEND) begin
      susp_fire = 1'b1;
      mode_n = 1'b1;
    end else if (accept) begin
      case (pend_q)
        PEND_ERASE: begin
          pend_n = PEND_NONE;
          mode_n = 1'b1;
          if (wr_data != CMD_CONFIRM) begin
            set_err[ERR_ERASE] = 1'b1;
            set_err[ERR_PROG] = 1'b1;
          end else if (!vpp_ok) begin
            set_err[ERR_ERASE] = 1'b1;
            set_err[ERR_VPP] = 1'b1;
          end else if (blk_locked) begin
            set_err[ERR_ERASE] = 1'b1;
            set_err[ERR_LOCK] = 1'b1;
          end else if (wsm_susp) set_err[ERR_ERASE] = 1'b1;
          else start_erase = 1'b1;
        end
        PEND_PROG: begin
          pend_n = PEND_NONE;
          mode_n = 1'b1;
          if (!vpp_ok) begin
            set_err[ERR_PROG] = 1'b1;
            set_err[ERR_VPP] = 1'b1;
          end else if (blk_locked) begin
            set_err[ERR_PROG] = 1'b1;
            set_err[ERR_LOCK] = 1'b1;
          end else if (wsm_susp && wr_blk == act_blk) set_err[ERR_PROG] = 1'b1;
          else start_prog = 1'b1;
        end
        default: begin
          case (wr_data)
            CMD_ERASE_SETUP: begin pend_n = PEND_ERASE; mode_n = 1'b1; end
            CMD_PROG_SETUP:  begin pend_n = PEND_PROG;  mode_n = 1'b1; end
            CMD_CLEAR:       clr_fire = 1'b1;
            CMD_READ_ARRAY:  mode_n = 1'b0;
            CMD_CONFIRM: if (wsm_state == WS_SUSPENDED) begin
              resume_fire = 1'b1;
              mode_n = 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
      pend_q <= PEND_NONE;
      read_status <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      pend_q <= pend_n;
      read_status <= mode_n;
      err_q <= clr_fire ? '0 : (err_q | set_err);
      if (start_prog) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
    end
  end

  flash_wsm #(
    .ERASE_CYCLES(ERASE_CYCLES), .SUSPEND_LAT(SUSPEND_LAT),
    .PROG_CYCLES(PROG_CYCLES), .BLK_W(BLK_W)
  ) u_wsm (
    .clk, .rst_n,
    .start_erase, .start_prog,
    .req_susp(susp_fire), .req_resume(resume_fire),
    .erase_blk_i(wr_blk),
    .state_o(wsm_state), .ready_o(wsm_ready), .susp_o(wsm_susp),
    .erase_blk_o(act_blk), .erase_done_o(erase_done), .prog_done_o(prog_done)
  );

  flash_cells #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) u_cells (
    .clk, .rst_n,
    .erase_en(erase_done), .erase_blk(act_blk),
    .prog_en(prog_done), .prog_addr(op_addr), .prog_data(op_data),
    .rd_addr, .rd_q(cell_q)
  );

  assign status  = pack_status(wsm_ready, wsm_susp, err_q);
  assign sts_pin = status[7];
  assign rd_data = read_status ? status : cell_q;

  // R7: error flags never drop without an accepted clear
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_fire) |-> ((err_q & $past(err_q)) == $past(err_q)));

  // R7: writes during a running operation leave the flags alone
  assert_busy_clear_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wsm_ready) |=> err_q == $past(err_q));

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

  localparam int NB = 4, BB = 8, EC = 40, SL = 3, PC = 4;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, vpp_ok = 1'b1, sts_pin;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [NB-1:0] lock_in = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BB), .ERASE_CYCLES(EC),
                   .SUSPEND_LAT(SL), .PROG_CYCLES(PC)) dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .vpp_ok, .lock_in, .sts_pin);

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [AW-1:0] a, logic [7:0] exp);
    rd_addr = a; #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 pin", {7'd0, sts_pin}, 8'h01);
    rd("R1 byte0", 0, 8'hFF);
    rd("R1 byte31", 31, 8'hFF);
  endtask

  task automatic t_program;
    wr(9, 8'h40); wr(9, 8'h5A);
    tick(PC - 1);
    rd("R2 busy status", 0, 8'h00);
    chk("R2 busy pin", {7'd0, sts_pin}, 8'h00);
    tick(1);
    rd("R2 done status", 0, 8'h80);
    wr(0, 8'hFF);
    rd("R2 byte", 9, 8'h5A);
    wr(9, 8'h40); wr(9, 8'h0F); tick(PC);
    wr(0, 8'hFF);
    rd("R2 and", 9, 8'h0A);
  endtask

  task automatic t_erase;
    wr(16, 8'h40); wr(16, 8'h00); tick(PC);
    wr(17, 8'h20); wr(17, 8'hD0);
    tick(EC - 1);
    rd("R3 busy", 0, 8'h00);
    chk("R3 busy pin", {7'd0, sts_pin}, 8'h00);
    tick(1);
    rd("R3 done", 0, 8'h80);
    wr(0, 8'hFF);
    rd("R3 first", 16, 8'hFF);
    rd("R3 last", 23, 8'hFF);
    rd("R3 other block", 9, 8'h0A);
  endtask

  task automatic t_bad_confirm;
    wr(9, 8'h20); wr(9, 8'h33);
    rd("R4 status", 0, 8'hB0);
    tick(EC + 1);
    rd("R4 still idle", 0, 8'hB0);
    wr(0, 8'h50);
    rd("R7 clear", 0, 8'h80);
    wr(0, 8'hFF);
    rd("R4 untouched", 9, 8'h0A);
  endtask

  task automatic t_vpp;
    vpp_ok = 1'b0;
    wr(9, 8'h20); wr(9, 8'hD0);
    rd("R5 erase", 0, 8'hA8);
    wr(0, 8'h50);
    rd("R7 clear low vpp", 0, 8'h80);
    wr(9, 8'h40); wr(9, 8'h00);
    tick(PC + 1);
    rd("R5 prog", 0, 8'h98);
    wr(0, 8'h50); wr(0, 8'hFF);
    rd("R5 untouched", 9, 8'h0A);
    vpp_ok = 1'b1;
  endtask

  task automatic t_lock;
    lock_in = 4'b0010;
    wr(9, 8'h20); wr(9, 8'hD0);
    tick(EC + 1);
    rd("R6 erase", 0, 8'hA2);
    wr(0, 8'h50);
    wr(9, 8'h40); wr(9, 8'h00);
    tick(PC + 1);
    rd("R6 prog", 0, 8'h92);
    wr(0, 8'h50); wr(0, 8'hFF);
    rd("R6 untouched", 9, 8'h0A);
    lock_in = '0;
  endtask

  task automatic t_sticky;
    wr(9, 8'h20); wr(9, 8'h11);
    wr(11, 8'h40); wr(11, 8'h0F); tick(PC);
    rd("R7 kept after prog", 0, 8'hB0);
    wr(0, 8'h20); wr(0, 8'hD0);
    wr(0, 8'h50);
    rd("R7 busy clear ignored", 0, 8'h30);
    tick(EC);
    rd("R7 kept after erase", 0, 8'hB0);
    wr(0, 8'h50);
    rd("R7 cleared", 0, 8'h80);
  endtask

  task automatic t_suspend;
    wr(24, 8'h40); wr(24, 8'h00); tick(PC);
    wr(24, 8'h20); wr(24, 8'hD0);
    tick(10);
    wr(0, 8'hB0);
    tick(SL - 1);
    rd("R9 latency", 0, 8'h00);
    tick(1);
    rd("R9 suspended", 0, 8'hC0);
    chk("R9 pin", {7'd0, sts_pin}, 8'h01);
    wr(0, 8'hFF);
    rd("R9 not erased", 24, 8'h00);
    rd("R8 other block", 9, 8'h0A);
    wr(10, 8'h40); wr(10, 8'h3C);
    rd("R10 prog in suspend", 0, 8'h40);
    chk("R10 pin low", {7'd0, sts_pin}, 8'h00);
    tick(PC);
    rd("R10 back to suspend", 0, 8'hC0);
    wr(25, 8'h40); wr(25, 8'h00);
    rd("R10 suspended block prog", 0, 8'hD0);
    wr(0, 8'h50);
    rd("R7 clear in suspend", 0, 8'hC0);
    wr(8, 8'h20); wr(8, 8'hD0);
    rd("R10 erase in suspend", 0, 8'hE0);
    wr(0, 8'h50);
    wr(0, 8'hD0);
    rd("R11 resumed", 0, 8'h00);
    tick(EC - (11 + SL) - 1);
    rd("R11 remaining busy", 0, 8'h00);
    tick(1);
    rd("R11 done", 0, 8'h80);
    wr(0, 8'hFF);
    rd("R11 erased", 24, 8'hFF);
    rd("R11 prog kept", 10, 8'h3C);
  endtask

  task automatic t_race;
    wr(0, 8'h40); wr(0, 8'h11); tick(PC);
    wr(0, 8'h20); wr(0, 8'hD0);
    tick(EC - 2);
    wr(0, 8'hB0);
    rd("R12 pending", 0, 8'h00);
    tick(1);
    rd("R12 completes", 0, 8'h80);
    tick(SL);
    rd("R12 no suspend", 0, 8'h80);
    wr(0, 8'hFF);
    rd("R12 erased", 0, 8'hFF);
  endtask

  task automatic t_idle_suspend;
    wr(0, 8'hB0);
    rd("R9 idle suspend ignored", 9, 8'h0A);
    chk("R9 idle pin", {7'd0, sts_pin}, 8'h01);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_program();
    t_erase();
    t_bad_confirm();
    t_vpp();
    t_lock();
    t_sticky();
    t_suspend();
    t_race();
    t_idle_suspend();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule